// File: doc/BRIEF.md
# Synchronous burst SRAM front end

This block is the clocked control side of a pipelined burst SRAM. It has two address strobes: one for a processor and one for a memory controller. Three chip enables form the device selection. An advance input steps through a four-word burst. There is a global write enable and a byte write enable with one select per byte lane. Every control input is sampled on the rising clock edge. The registered address takes its two low bits from a burst counter. That counter is loaded from the external address and then advanced one beat per clock while advance is held low.

Every clock edge performs one access at the current address, provided the device is selected. A write access updates the enabled byte lanes of the internal array at that edge. A read access is pipelined. The word appears on the data output one cycle after the edge that registered its address. It is marked by a valid flag, which stands in for pads that are actually driven. Output enable is asynchronous and active low, and it gates that flag. The first read after a deselected period is always suppressed. Linear burst order is the default. A parameter switches to interleaved order, where the beat number is XORed into the start address.

Top module: `sbsram_ctrl`

## Requirements
- R1: A new address is loaded from `addr_i` at an edge where `ctl_stb_n` is low, or where `cpu_stb_n` and `sel_a_n` are both low. That edge's access, and the bursts that follow, start from this address.
- R2: When both strobes are low and `sel_a_n` is low, the processor strobe wins. That access is always a read, and the write controls have no effect on the array.
- R3: With `sel_a_n` high, `cpu_stb_n` is ignored. If `ctl_stb_n` is also high, no address is loaded, and the selection and address stay as they were.
- R4: Selection is (`sel_a_n` low, `sel_b` high, `sel_c_n` low), sampled only at load edges. At all other edges, changes on the three enables have no effect.
- R5: At an edge with no load and `adv_n` low, the address moves to the next beat. In linear order the low two bits are (start + beat) mod 4, and the upper bits do not change. With `adv_n` high and no load, the address is held.
- R6: A selected access with `all_wr_n` low and no processor load writes all byte lanes from `wdata`. `lane_wr_n` and `lane_sel_n` are ignored.
- R7: With `all_wr_n` high and `lane_wr_n` low, lane k (data bits 8k+7..8k) is written only when `lane_sel_n[k]` is low. The other lanes keep their contents.
- R8: After reset the block is deselected. A deselected access writes nothing and produces no read output.
- R9: A selected read with both write enables high drives the word at its address on `rdata`, with `rvalid` high, in the cycle after the edge that performed the access.
- R10: While `oe_n` is high, `rvalid` is low and `rdata` is zero, regardless of pending reads.
- R11: A read performed at an edge where the previous selection state was deselected has its output cycle masked. That cycle shows `rvalid` low and `rdata` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | External word address |
| cpu_stb_n | input | 1 | Processor address strobe, active low |
| ctl_stb_n | input | 1 | Controller address strobe, active low |
| sel_a_n | input | 1 | First chip enable, active low, also gates the processor strobe |
| sel_b | input | 1 | Second chip enable, active high |
| sel_c_n | input | 1 | Third chip enable, active low |
| adv_n | input | 1 | Burst advance, active low |
| all_wr_n | input | 1 | Global write enable, active low |
| lane_wr_n | input | 1 | Byte write enable, active low |
| lane_sel_n | input | LANES | Per-lane write selects, active low |
| wdata | input | LANES*LANE_W | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | LANES*LANE_W | Read data, zero when not valid |
| rvalid | output | 1 | Read data is being driven |

## Verification
The assertions assume that every control input is a clean 0 or 1 at each rising edge. They also assume the address register starts from a consistent reset value, so the hold and advance properties compare the new address against the previous one. The stimulus changes every input only on the falling edge and keeps addresses inside a range that was written first. Bursts that run past the end of a four-word block wrap inside that block rather than leaving it.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

    // Kind of access performed at a clock edge
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_e;

    localparam int BEAT_W = 2;

    // Low address bits for a given beat of a four-word burst
    function automatic logic [BEAT_W-1:0] beat_lo(
        input logic [BEAT_W-1:0] start,
        input logic [BEAT_W-1:0] beat,
        input bit                xor_order
    );
        logic [BEAT_W-1:0] r;
        if (xor_order) r = start ^ beat;
        else           r = start + beat;
        return r;
    endfunction

endpackage

// File: rtl/sbsram_addr_seq.sv
module sbsram_addr_seq
    import sbsram_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter bit INTERLEAVE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              cpu_stb_n,
    input  logic              ctl_stb_n,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              sel_c_n,
    input  logic              adv_n,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              cur_sel,
    output logic              prev_sel,
    output logic [ADDR_W-1:0] addr_q,
    output logic              cpu_take
);

    localparam int HI_W = ADDR_W - BEAT_W;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [BEAT_W-1:0] beat;
        logic              sel;
        logic [ADDR_W-1:0] addr;
    } seq_t;

    seq_t q, d;
    logic load;

    always_comb begin
        d        = q;
        // R2/R3: processor strobe only counts while the first enable is active
        cpu_take = !cpu_stb_n && !sel_a_n;
        load     = cpu_take || !ctl_stb_n;

        if (load) begin
            // R1/R4: capture address and sample selection only here
            d.base = addr_i;
            d.beat = '0;
            d.sel  = !sel_a_n && sel_b && !sel_c_n;
        end else if (!adv_n) begin
            // R5: next beat, wrapping inside the block
            d.beat = q.beat + 1'b1;
        end

        d.addr = {d.base[ADDR_W-1 -: HI_W],
                  beat_lo(d.base[BEAT_W-1:0], d.beat, INTERLEAVE)};

        cur_addr = d.addr;
        cur_sel  = d.sel;
        prev_sel = q.sel;
        addr_q   = q.addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/sbsram_wr_dec.sv
module sbsram_wr_dec
    import sbsram_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             all_wr_n,
    input  logic             lane_wr_n,
    input  logic [LANES-1:0] lane_sel_n,
    input  logic             cur_sel,
    input  logic             cpu_take,
    output logic [LANES-1:0] lane_we,
    output acc_e             kind
);

    logic wr_intent;

    always_comb begin
        wr_intent = !all_wr_n || !lane_wr_n;
        if (!cur_sel)                     kind = ACC_IDLE;   // R8
        else if (wr_intent && !cpu_take)  kind = ACC_WRITE;  // R2: processor load reads
        else                              kind = ACC_READ;
    end

    // R6/R7: per-lane enables
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_we[g] = (kind == ACC_WRITE) && (!all_wr_n || !lane_sel_n[g]);
    end

endmodule

// File: rtl/sbsram_store.sv
module sbsram_store #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       acc_addr,
    input  logic [LANES-1:0]        lane_we,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    rd_go,
    input  logic                    rd_mask,
    output logic [LANES*LANE_W-1:0] out_data,
    output logic                    out_valid,
    output logic                    out_masked
);

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int DATA_W = LANES * LANE_W;

    typedef struct packed {
        logic              pend;
        logic              pmask;
        logic [ADDR_W-1:0] raddr;
        logic              valid;
        logic              masked;
        logic [DATA_W-1:0] data;
    } pipe_t;

    logic [DATA_W-1:0] mem [DEPTH];
    pipe_t q, d;

    always_comb begin
        d        = q;
        // stage 1: access registered
        d.pend   = rd_go;
        d.pmask  = rd_mask;
        d.raddr  = acc_addr;
        // stage 2: data presented (R9)
        d.valid  = q.pend;
        d.masked = q.pmask;
        d.data   = mem[q.raddr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        for (int l = 0; l < LANES; l++) begin
            if (lane_we[l]) mem[acc_addr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
        end
    end

    assign out_data   = q.data;
    assign out_valid  = q.valid;
    assign out_masked = q.masked;

endmodule

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl
    import sbsram_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int LANES      = 4,
    parameter int LANE_W     = 8,
    parameter bit INTERLEAVE = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic                    cpu_stb_n,
    input  logic                    ctl_stb_n,
    input  logic                    sel_a_n,
    input  logic                    sel_b,
    input  logic                    sel_c_n,
    input  logic                    adv_n,
    input  logic                    all_wr_n,
    input  logic                    lane_wr_n,
    input  logic [LANES-1:0]        lane_sel_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    oe_n,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rvalid
);

    localparam int DATA_W = LANES * LANE_W;

    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] addr_q;
    logic              cur_sel;
    logic              prev_sel;
    logic              cpu_take;
    logic [LANES-1:0]  lane_we;
    acc_e              kind;
    logic              rd_go;
    logic              rd_mask;
    logic [DATA_W-1:0] out_data;
    logic              out_valid;
    logic              out_masked;

    sbsram_addr_seq #(
        .ADDR_W    (ADDR_W),
        .INTERLEAVE(INTERLEAVE)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_i   (addr_i),
        .cpu_stb_n(cpu_stb_n),
        .ctl_stb_n(ctl_stb_n),
        .sel_a_n  (sel_a_n),
        .sel_b    (sel_b),
        .sel_c_n  (sel_c_n),
        .adv_n    (adv_n),
        .cur_addr (cur_addr),
        .cur_sel  (cur_sel),
        .prev_sel (prev_sel),
        .addr_q   (addr_q),
        .cpu_take (cpu_take)
    );

    sbsram_wr_dec #(
        .LANES(LANES)
    ) u_dec (
        .all_wr_n  (all_wr_n),
        .lane_wr_n (lane_wr_n),
        .lane_sel_n(lane_sel_n),
        .cur_sel   (cur_sel),
        .cpu_take  (cpu_take),
        .lane_we   (lane_we),
        .kind      (kind)
    );

    // R11: a read straight after a deselected period is masked
    assign rd_go   = (kind == ACC_READ);
    assign rd_mask = rd_go && !prev_sel;

    sbsram_store #(
        .ADDR_W(ADDR_W),
        .LANES (LANES),
        .LANE_W(LANE_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_addr  (cur_addr),
        .lane_we   (lane_we),
        .wdata     (wdata),
        .rd_go     (rd_go),
        .rd_mask   (rd_mask),
        .out_data  (out_data),
        .out_valid (out_valid),
        .out_masked(out_masked)
    );

    // R10: asynchronous output-enable gate
    assign rvalid = out_valid && !out_masked && !oe_n;
    assign rdata  = rvalid ? out_data : '0;

endmodule

// File: rtl/sbsram_chk.sv
module sbsram_chk #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_i,
    input logic              cpu_stb_n,
    input logic              ctl_stb_n,
    input logic              sel_a_n,
    input logic              adv_n,
    input logic              all_wr_n,
    input logic              lane_wr_n,
    input logic [LANES-1:0]  lane_sel_n,
    input logic              oe_n,
    input logic              rvalid,
    input logic [ADDR_W-1:0] cur_addr,
    input logic [ADDR_W-1:0] addr_q,
    input logic              cur_sel,
    input logic              prev_sel,
    input logic [LANES-1:0]  lane_we
);

    logic cpu_ok;
    logic ld;
    assign cpu_ok = !cpu_stb_n && !sel_a_n;
    assign ld     = cpu_ok || !ctl_stb_n;

    assert_load_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ld |-> cur_addr == addr_i)
        else $error("R1 loaded address mismatch");

    assert_cpu_read_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ok |-> lane_we == '0)
        else $error("R2 write on processor load");

    assert_hold_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |-> cur_sel == prev_sel)
        else $error("R4 selection changed without load");

    assert_hold_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && adv_n) |-> cur_addr == addr_q)
        else $error("R5 address moved without advance");

    assert_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !adv_n) |-> (cur_addr[ADDR_W-1:2] == addr_q[ADDR_W-1:2] &&
                             cur_addr[1:0] != addr_q[1:0]))
        else $error("R5 bad burst step");

    assert_global_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!all_wr_n && cur_sel && !cpu_ok) |-> &lane_we)
        else $error("R6 global write missed lanes");

    assert_byte_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (all_wr_n && !lane_wr_n && cur_sel && !cpu_ok) |-> lane_we == ~lane_sel_n)
        else $error("R7 lane enables wrong");

    assert_desel_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_sel |-> lane_we == '0)
        else $error("R8 write while deselected");

    assert_oe_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !rvalid)
        else $error("R10 valid with output disabled");

endmodule

bind sbsram_ctrl sbsram_chk #(
    .ADDR_W(ADDR_W),
    .LANES (LANES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_i    (addr_i),
    .cpu_stb_n (cpu_stb_n),
    .ctl_stb_n (ctl_stb_n),
    .sel_a_n   (sel_a_n),
    .adv_n     (adv_n),
    .all_wr_n  (all_wr_n),
    .lane_wr_n (lane_wr_n),
    .lane_sel_n(lane_sel_n),
    .oe_n      (oe_n),
    .rvalid    (rvalid),
    .cur_addr  (cur_addr),
    .addr_q    (addr_q),
    .cur_sel   (cur_sel),
    .prev_sel  (prev_sel),
    .lane_we   (lane_we)
);

// File: tb/tb_sbsram_ctrl.sv
`timescale 1ns/1ps
module tb_sbsram_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr_i = '0;
    logic        cpu_stb_n = 1'b1;
    logic        ctl_stb_n = 1'b1;
    logic        sel_a_n = 1'b0;
    logic        sel_b = 1'b1;
    logic        sel_c_n = 1'b0;
    logic        adv_n = 1'b1;
    logic        all_wr_n = 1'b1;
    logic        lane_wr_n = 1'b1;
    logic [3:0]  lane_sel_n = 4'hF;
    logic [31:0] wdata = '0;
    logic        oe_n = 1'b0;
    logic [31:0] rdata;
    logic        rvalid;

    int    checks = 0;
    int    errors = 0;
    string tag = "R8";

    always #2.5 clk = ~clk;

    sbsram_ctrl dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
        .cpu_stb_n(cpu_stb_n), .ctl_stb_n(ctl_stb_n),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .adv_n(adv_n), .all_wr_n(all_wr_n), .lane_wr_n(lane_wr_n),
        .lane_sel_n(lane_sel_n), .wdata(wdata), .oe_n(oe_n),
        .rdata(rdata), .rvalid(rvalid)
    );

    // ---------------- reference model ----------------
    logic [31:0] mm [0:255];
    logic [7:0]  m_base;
    logic [1:0]  m_beat;
    logic        m_sel;
    logic        p_rd, p_mask;
    logic [7:0]  p_addr;
    logic        e_rd, e_mask;
    logic [31:0] e_data;
    logic        m_cpu, m_ld, m_wr, m_prev;
    logic [7:0]  m_cur;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_base = '0; m_beat = '0; m_sel = 1'b0;
            p_rd = 1'b0; p_mask = 1'b0; p_addr = '0;
            e_rd = 1'b0; e_mask = 1'b0; e_data = '0;
        end else begin
            e_rd   = p_rd;
            e_mask = p_mask;
            e_data = mm[p_addr];
            m_cpu  = !cpu_stb_n && !sel_a_n;
            m_ld   = m_cpu || !ctl_stb_n;
            m_prev = m_sel;
            if (m_ld) begin
                m_base = addr_i;
                m_beat = 2'd0;
                m_sel  = !sel_a_n && sel_b && !sel_c_n;
            end else if (!adv_n) begin
                m_beat = m_beat + 2'd1;
            end
            m_cur = {m_base[7:2], m_base[1:0] + m_beat};
            m_wr  = m_sel && !m_cpu && (!all_wr_n || !lane_wr_n);
            if (m_wr) begin
                for (int k = 0; k < 4; k++)
                    if (!all_wr_n || !lane_sel_n[k]) mm[m_cur][8*k +: 8] = wdata[8*k +: 8];
            end
            p_rd   = m_sel && !m_wr;
            p_mask = p_rd && !m_prev;
            p_addr = m_cur;
        end
    end

    task automatic check_out();
        logic        ev;
        logic [31:0] ed;
        ev = e_rd && !e_mask && !oe_n;
        ed = ev ? e_data : 32'h0;
        checks++;
        if (rvalid !== ev || rdata !== ed) begin
            errors++;
            $display("FAIL %s t=%0t rvalid=%b exp=%b rdata=%h exp=%h",
                     tag, $time, rvalid, ev, rdata, ed);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        check_out();
    endtask

    task automatic acc(input logic c_n, input logic k_n, input logic [7:0] a,
                       input logic g_n, input logic b_n, input logic [3:0] l_n,
                       input logic [31:0] w, input logic v_n);
        cpu_stb_n = c_n; ctl_stb_n = k_n; addr_i = a;
        all_wr_n = g_n; lane_wr_n = b_n; lane_sel_n = l_n;
        wdata = w; adv_n = v_n;
        tick();
    endtask

    task automatic idle(input int n);
        repeat (n) acc(1'b1, 1'b1, addr_i, 1'b1, 1'b1, 4'hF, wdata, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tag = "R8";                       // reset state: deselected, no output
        idle(3);

        tag = "R6";                       // preload with global writes
        for (int i = 0; i < 32; i++)
            acc(1'b1, 1'b0, 8'(i), 1'b0, 1'b1, 4'h0, 32'hA5000000 ^ (i * 32'h01010101), 1'b1);
        idle(2);

        tag = "R9";                       // controller read, pipelined
        acc(1'b1, 1'b0, 8'd3, 1'b1, 1'b1, 4'hF, 32'h0, 1'b1);
        idle(3);

        tag = "R1";                       // processor strobe load
        acc(1'b0, 1'b1, 8'd9, 1'b1, 1'b1, 4'hF, 32'h0, 1'b1);
        idle(3);

        tag = "R7";                       // lanes 0 and 2 written only
        acc(1'b1, 1'b0, 8'd5, 1'b1, 1'b0, 4'b1010, 32'h11223344, 1'b1);
        acc(1'b1, 1'b0, 8'd5, 1'b1, 1'b1, 4'hF, 32'h0, 1'b1);
        idle(3);

        tag = "R2";                       // both strobes: processor wins, no write
        acc(1'b0, 1'b0, 8'd12, 1'b0, 1'b0, 4'h0, 32'hFFFFFFFF, 1'b1);
        idle(3);
        acc(1'b1, 1'b0, 8'd12, 1'b1, 1'b1, 4'hF, 32'h0, 1'b1);
        idle(3);

        tag = "R3";                       // processor strobe ignored when sel_a_n high
        sel_a_n = 1'b1;
        acc(1'b0, 1'b1, 8'd20, 1'b1, 1'b1, 4'hF, 32'h0, 1'b1);
        idle(2);
        acc(1'b0, 1'b0, 8'd21, 1'b1, 1'b1, 4'hF, 32'h0, 1'b1);
        idle(2);
        sel_a_n = 1'b0;
        acc(1'b1, 1'b0, 8'd14, 1'b1, 1'b1, 4'hF, 32'h0, 1'b1);

        tag = "R4";                       // enables ignored without a load
        sel_b = 1'b0; sel_c_n = 1'b1;
        idle(4);
        sel_b = 1'b1; sel_c_n = 1'b0;
        idle(2);

        tag = "R5";                       // burst write from 17 then burst read from 6
        acc(1'b1, 1'b0, 8'd17, 1'b0, 1'b1, 4'h0, 32'hC0DE0001, 1'b1);
        for (int b = 1; b < 4; b++)
            acc(1'b1, 1'b1, 8'd0, 1'b0, 1'b1, 4'h0, 32'hC0DE0000 + 32'(b + 1), 1'b0);
        acc(1'b1, 1'b0, 8'd17, 1'b1, 1'b1, 4'hF, 32'h0, 1'b1);
        for (int b = 0; b < 5; b++) acc(1'b1, 1'b1, 8'd0, 1'b1, 1'b1, 4'hF, 32'h0, 1'b0);
        acc(1'b1, 1'b0, 8'd6, 1'b1, 1'b1, 4'hF, 32'h0, 1'b1);
        for (int b = 0; b < 3; b++) acc(1'b1, 1'b1, 8'd0, 1'b1, 1'b1, 4'hF, 32'h0, 1'b0);
        idle(3);

        tag = "R8";                       // deselected write is dropped
        sel_c_n = 1'b1;
        acc(1'b1, 1'b0, 8'd2, 1'b0, 1'b1, 4'h0, 32'hDEADBEEF, 1'b1);
        sel_c_n = 1'b0;
        idle(2);
        acc(1'b1, 1'b0, 8'd2, 1'b1, 1'b1, 4'hF, 32'h0, 1'b1);
        idle(3);

        tag = "R11";                      // first read after deselect masked
        sel_b = 1'b0;
        acc(1'b1, 1'b0, 8'd8, 1'b1, 1'b1, 4'hF, 32'h0, 1'b1);
        sel_b = 1'b1;
        idle(1);
        acc(1'b1, 1'b0, 8'd10, 1'b1, 1'b1, 4'hF, 32'h0, 1'b1);
        for (int b = 0; b < 3; b++) acc(1'b1, 1'b1, 8'd0, 1'b1, 1'b1, 4'hF, 32'h0, 1'b0);
        idle(3);

        tag = "R10";                      // output enable gate
        acc(1'b1, 1'b0, 8'd11, 1'b1, 1'b1, 4'hF, 32'h0, 1'b1);
        oe_n = 1'b1;
        idle(3);
        oe_n = 1'b0;
        idle(2);

        tag = "R9";                       // mixed traffic against the model
        for (int n = 0; n < 4000; n++) begin
            sel_a_n = ($urandom_range(0, 7) == 0);
            sel_b   = ($urandom_range(0, 7) != 0);
            sel_c_n = ($urandom_range(0, 7) == 0);
            oe_n    = ($urandom_range(0, 7) == 0);
            acc($urandom_range(0, 4) != 0, $urandom_range(0, 2) != 0,
                8'($urandom_range(0, 31)), $urandom_range(0, 6) != 0,
                $urandom_range(0, 3) != 0, 4'($urandom_range(0, 15)),
                $urandom(), $urandom_range(0, 4) < 2);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule